// File: doc/BRIEF.md
# Saturating Float Result Conditioner

This block sits on both sides of a single-precision arithmetic datapath whose number system has no infinities and no denormals. On the way in, it cleans each of two operands combinationally. A value with a zero exponent becomes a zero that keeps its sign. A value with an all-ones exponent becomes the largest finite magnitude with the same sign. The arithmetic units therefore only ever see finite, normal-or-zero values.

On the way out, it takes one raw result per valid strobe and applies the same replacement. What it does to the 32-bit status word depends on a two-bit operation class. Additive and multiplicative results record overflow and underflow in a cause bit and in a sticky bit. Quotient-style results are clamped without touching the status word. Sign-only operations pass the raw value through and wipe the two cause bits. The conditioned result, a valid pulse and the updated status word all appear one clock after the strobe.

Top module: `fres_cond`

## Requirements
- R1: An operand whose exponent field (bits 30:23) is zero leaves on its output port as zero with its original sign bit (bit 31), whatever its mantissa. Other operands with an exponent that is neither zero nor all ones pass unchanged.
- R2: An operand whose exponent field is all ones (infinity or NaN) leaves as its sign bit combined with magnitude 0x7F7FFFFF.
- R3: For class 1 (arithmetic), a result whose exponent is all ones is replaced by sign | 0x7F7FFFFF and sets status bit 15 (overflow cause) and bit 4 (overflow sticky).
- R4: For class 1, a result with a zero exponent and a nonzero mantissa is replaced by a signed zero and sets status bit 14 (underflow cause) and bit 3 (underflow sticky). The overflow test has priority, so a single result never raises both.
- R5: For class 2 (divide), results are clamped as in R3 and R4, but the status word does not change.
- R6: For class 3 (sign-only: abs, negate, min, max), the raw result passes unchanged, status bits 15 and 14 are cleared, and all other status bits, the sticky bits included, keep their value.
- R7: For class 0 (pass), the raw result passes unchanged and the status word does not change.
- R8: For class 1, a finite normal result or an exact signed zero passes unchanged and sets no flag.
- R9: The result, the valid output and the status word register on the clock edge that samples `valid_i` high. The valid output is high for exactly that one cycle. While `valid_i` is low, the result and the status word hold.
- R10: After reset, the result, the valid output and the status word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Result strobe |
| op_class_i | input | 2 | 0 pass, 1 arithmetic, 2 divide, 3 sign-only |
| opa_i | input | 32 | First raw operand |
| opb_i | input | 32 | Second raw operand |
| res_i | input | 32 | Raw result from the datapath |
| opa_o | output | 32 | First conditioned operand |
| opb_o | output | 32 | Second conditioned operand |
| res_o | output | 32 | Registered conditioned result |
| res_valid_o | output | 1 | One-cycle pulse with each registered result |
| status_o | output | 32 | Control/status word with cause and sticky flags |

## Verification
The bench uses the default parameters: an 8-bit exponent, a 23-bit mantissa, and a 32-bit status word with its four flag bits at 15, 14, 4 and 3. Because the four flag bits are distinct, a flag landing on the wrong bit, or the cause and sticky halves being swapped, shows up directly against the model. The pseudo-random vectors force the exponent to zero or to all ones in about half the cases. This puts infinities, NaNs, denormals and signed zeros in every class, across a status word that builds up history between clear operations.

// File: rtl/fres_cond_pkg.sv
package fres_cond_pkg;

    typedef enum logic [1:0] {
        OPC_PASS  = 2'd0,
        OPC_ARITH = 2'd1,
        OPC_DIV   = 2'd2,
        OPC_SIGN  = 2'd3
    } opc_e;

endpackage

// File: rtl/fres_opnd_clamp.sv
module fres_opnd_clamp #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] val_i,
    output logic [EXP_W+MAN_W:0] val_o
);
    localparam int W = 1 + EXP_W + MAN_W;
    localparam logic [W-2:0] MAX_MAG = {{(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};

    logic             sgn;
    logic [EXP_W-1:0] expo;

    assign sgn  = val_i[W-1];
    assign expo = val_i[W-2:MAN_W];

    always_comb begin
        if (expo == '0) begin
            val_o = {sgn, {(W-1){1'b0}}};
        end else if (&expo) begin
            val_o = {sgn, MAX_MAG};
        end else begin
            val_o = val_i;
        end
    end
endmodule

// File: rtl/fres_res_check.sv
module fres_res_check #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] raw_i,
    output logic [EXP_W+MAN_W:0] clean_o,
    output logic                 big_o,
    output logic                 tiny_o
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] man;

    assign expo = raw_i[W-2:MAN_W];
    assign man  = raw_i[MAN_W-1:0];

    fres_opnd_clamp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_clamp (
        .val_i (raw_i),
        .val_o (clean_o)
    );

    // overflow wins: tiny only when the exponent is not saturated
    assign big_o  = &expo;
    assign tiny_o = !big_o && (expo == '0) && (man != '0);
endmodule

// File: rtl/fres_flag_merge.sv
module fres_flag_merge
    import fres_cond_pkg::*;
#(
    parameter int STAT_W     = 32,
    parameter int OVF_CAUSE  = 15,
    parameter int UNF_CAUSE  = 14,
    parameter int OVF_STICKY = 4,
    parameter int UNF_STICKY = 3
) (
    input  opc_e              cls_i,
    input  logic              big_i,
    input  logic              tiny_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [STAT_W-1:0] stat_o
);
    localparam logic [STAT_W-1:0] ONE       = {{(STAT_W-1){1'b0}}, 1'b1};
    localparam logic [STAT_W-1:0] OVF_MASK  = (ONE << OVF_CAUSE) | (ONE << OVF_STICKY);
    localparam logic [STAT_W-1:0] UNF_MASK  = (ONE << UNF_CAUSE) | (ONE << UNF_STICKY);
    localparam logic [STAT_W-1:0] CAUSE_MSK = (ONE << OVF_CAUSE) | (ONE << UNF_CAUSE);

    always_comb begin
        stat_o = stat_i;
        unique case (cls_i)
            OPC_ARITH: begin
                if (big_i)  stat_o = stat_o | OVF_MASK;
                if (tiny_i) stat_o = stat_o | UNF_MASK;
            end
            OPC_SIGN:  stat_o = stat_i & ~CAUSE_MSK;
            default:   stat_o = stat_i;
        endcase
    end
endmodule

// File: rtl/fres_cond.sv
module fres_cond
    import fres_cond_pkg::*;
#(
    parameter int EXP_W      = 8,
    parameter int MAN_W      = 23,
    parameter int STAT_W     = 32,
    parameter int OVF_CAUSE  = 15,
    parameter int UNF_CAUSE  = 14,
    parameter int OVF_STICKY = 4,
    parameter int UNF_STICKY = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid_i,
    input  logic [1:0]             op_class_i,
    input  logic [EXP_W+MAN_W:0]   opa_i,
    input  logic [EXP_W+MAN_W:0]   opb_i,
    input  logic [EXP_W+MAN_W:0]   res_i,
    output logic [EXP_W+MAN_W:0]   opa_o,
    output logic [EXP_W+MAN_W:0]   opb_o,
    output logic [EXP_W+MAN_W:0]   res_o,
    output logic                   res_valid_o,
    output logic [STAT_W-1:0]      status_o
);
    localparam int W      = 1 + EXP_W + MAN_W;
    localparam int N_OPND = 2;

    typedef struct packed {
        logic [W-1:0]      res;
        logic              vld;
        logic [STAT_W-1:0] stat;
    } state_t;

    state_t state_d, state_q;

    // operand side
    logic [N_OPND-1:0][W-1:0] opnd_raw, opnd_clean;
    assign opnd_raw = {opb_i, opa_i};

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        fres_opnd_clamp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_opnd (
            .val_i (opnd_raw[g]),
            .val_o (opnd_clean[g])
        );
    end

    assign opa_o = opnd_clean[0];
    assign opb_o = opnd_clean[1];

    // result side
    opc_e              cls;
    logic [W-1:0]      res_clean;
    logic              res_big, res_tiny;
    logic [STAT_W-1:0] stat_merged;

    assign cls = opc_e'(op_class_i);

    fres_res_check #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_res (
        .raw_i   (res_i),
        .clean_o (res_clean),
        .big_o   (res_big),
        .tiny_o  (res_tiny)
    );

    fres_flag_merge #(
        .STAT_W     (STAT_W),
        .OVF_CAUSE  (OVF_CAUSE),
        .UNF_CAUSE  (UNF_CAUSE),
        .OVF_STICKY (OVF_STICKY),
        .UNF_STICKY (UNF_STICKY)
    ) u_flags (
        .cls_i  (cls),
        .big_i  (res_big),
        .tiny_i (res_tiny),
        .stat_i (state_q.stat),
        .stat_o (stat_merged)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = valid_i;
        if (valid_i) begin
            unique case (cls)
                OPC_ARITH, OPC_DIV: state_d.res = res_clean;
                default:            state_d.res = res_i;
            endcase
            state_d.stat = stat_merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_o       = state_q.res;
    assign res_valid_o = state_q.vld;
    assign status_o    = state_q.stat;
endmodule

// File: rtl/fres_cond_chk.sv
module fres_cond_chk #(
    parameter int EXP_W      = 8,
    parameter int MAN_W      = 23,
    parameter int STAT_W     = 32,
    parameter int OVF_CAUSE  = 15,
    parameter int UNF_CAUSE  = 14,
    parameter int OVF_STICKY = 4,
    parameter int UNF_STICKY = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 valid_i,
    input logic [1:0]           op_class_i,
    input logic [EXP_W+MAN_W:0] opa_i,
    input logic [EXP_W+MAN_W:0] opb_i,
    input logic [EXP_W+MAN_W:0] res_i,
    input logic [EXP_W+MAN_W:0] opa_o,
    input logic [EXP_W+MAN_W:0] opb_o,
    input logic [EXP_W+MAN_W:0] res_o,
    input logic                 res_valid_o,
    input logic [STAT_W-1:0]    status_o
);
    localparam int W = 1 + EXP_W + MAN_W;
    localparam logic [W-2:0] MAX_MAG = {{(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};

    // R1
    opnd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opa_i[W-2:MAN_W] == '0) |-> (opa_o == {opa_i[W-1], {(W-1){1'b0}}}));

    // R2
    opnd_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&opb_i[W-2:MAN_W]) |-> (opb_o == {opb_i[W-1], MAX_MAG}));

    // R3
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_class_i == 2'd1 && (&res_i[W-2:MAN_W]))
        |=> (status_o[OVF_CAUSE] && status_o[OVF_STICKY] && res_o[W-2:0] == MAX_MAG));

    // R4
    unf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_class_i == 2'd1 && res_i[W-2:MAN_W] == '0 && res_i[MAN_W-1:0] != '0)
        |=> (status_o[UNF_CAUSE] && status_o[UNF_STICKY] && res_o[W-2:0] == '0));

    // R5
    div_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_class_i == 2'd2) |=> $stable(status_o));

    // R6
    sign_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_class_i == 2'd3)
        |=> (!status_o[OVF_CAUSE] && !status_o[UNF_CAUSE]
             && $stable(status_o[OVF_STICKY]) && $stable(status_o[UNF_STICKY])));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(res_o) && $stable(status_o) && !res_valid_o));

    // R3
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(status_o[OVF_STICKY]) && !$fell(status_o[UNF_STICKY]));
endmodule

bind fres_cond fres_cond_chk #(
    .EXP_W      (EXP_W),
    .MAN_W      (MAN_W),
    .STAT_W     (STAT_W),
    .OVF_CAUSE  (OVF_CAUSE),
    .UNF_CAUSE  (UNF_CAUSE),
    .OVF_STICKY (OVF_STICKY),
    .UNF_STICKY (UNF_STICKY)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .op_class_i  (op_class_i),
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .res_i       (res_i),
    .opa_o       (opa_o),
    .opb_o       (opb_o),
    .res_o       (res_o),
    .res_valid_o (res_valid_o),
    .status_o    (status_o)
);

// File: tb/fres_cond_tb.sv
module fres_cond_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, valid;
    logic [1:0]  cls;
    logic [31:0] a, b, r;
    logic [31:0] opa_o, opb_o, res_o, status_o;
    logic        res_valid_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_res, m_stat;
    logic        m_vld;

    fres_cond u_dut (
        .clk (clk), .rst_n (rst_n), .valid_i (valid), .op_class_i (cls),
        .opa_i (a), .opb_i (b), .res_i (r),
        .opa_o (opa_o), .opb_o (opb_o), .res_o (res_o),
        .res_valid_o (res_valid_o), .status_o (status_o)
    );

    function automatic logic [31:0] m_clean(input logic [31:0] x);
        int e = int'(x[30:23]);
        if (e == 0)   return x & 32'h8000_0000;
        if (e == 255) return x[31] ? 32'hFF7F_FFFF : 32'h7F7F_FFFF;
        return x;
    endfunction

    function automatic string opnd_tag(input logic [31:0] x);
        return (x[30:23] == 8'hFF) ? "R2" : "R1";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int c, input logic [31:0] va, input logic [31:0] vb,
                        input logic [31:0] vr, input bit v, input string tag);
        int  e;
        bit  man_nz;
        valid = v; cls = c[1:0]; a = va; b = vb; r = vr;
        #1;
        chk({opnd_tag(va), " opa"}, opa_o, m_clean(va));
        chk({opnd_tag(vb), " opb"}, opb_o, m_clean(vb));
        e      = int'(vr[30:23]);
        man_nz = (vr[22:0] != 0);
        if (v) begin
            case (c)
                0: m_res = vr;
                1: begin
                    m_res = m_clean(vr);
                    if (e == 255)              m_stat = m_stat | 32'h0000_8010;
                    else if (e == 0 && man_nz) m_stat = m_stat | 32'h0000_4008;
                end
                2: m_res = m_clean(vr);
                default: begin
                    m_res  = vr;
                    m_stat = m_stat & ~32'h0000_C000;
                end
            endcase
        end
        m_vld = v;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " result"}, res_o, m_res);
        chk({tag, " status"}, status_o, m_stat);
        chk("R9 valid", {31'b0, res_valid_o}, {31'b0, m_vld});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        rst_n = 1'b0; valid = 1'b0; cls = 2'd0; a = '0; b = '0; r = '0;
        m_res = '0; m_stat = '0; m_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 reset result", res_o, 32'h0);
        chk("R10 reset status", status_o, 32'h0);
        chk("R10 reset valid", {31'b0, res_valid_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 ordinary and zero results
        step(1, 32'h3F80_0000, 32'h4049_0FDB, 32'h3F80_0000, 1'b1, "R8");
        step(1, 32'h0040_0000, 32'hFF80_0000, 32'h8000_0000, 1'b1, "R8");
        // R3 overflow: +inf, -inf, NaN
        step(1, 32'h7FFF_FFFF, 32'h8000_0005, 32'h7F80_0000, 1'b1, "R3");
        step(1, 32'h7F80_0000, 32'h0000_0001, 32'hFF80_0000, 1'b1, "R3");
        step(1, 32'h1234_5678, 32'h7FC0_0000, 32'h7FC0_0001, 1'b1, "R3");
        // R6 clears cause, keeps sticky
        step(3, 32'h0, 32'h0, 32'h7F80_0000, 1'b1, "R6");
        // R4 underflow
        step(1, 32'h0, 32'h0, 32'h0000_0001, 1'b1, "R4");
        step(1, 32'h0, 32'h0, 32'h807F_FFFF, 1'b1, "R4");
        step(3, 32'h0, 32'h0, 32'h8000_0003, 1'b1, "R6");
        // R5 divide clamps silently
        step(2, 32'h0, 32'h0, 32'hFF80_0000, 1'b1, "R5");
        step(2, 32'h0, 32'h0, 32'h0000_0ABC, 1'b1, "R5");
        // R7 pass class
        step(0, 32'h0, 32'h0, 32'h7F80_0000, 1'b1, "R7");
        step(0, 32'h0, 32'h0, 32'h0000_0001, 1'b1, "R7");
        // R9 hold while idle
        step(1, 32'h0, 32'h0, 32'h7F80_0000, 1'b0, "R9");
        step(3, 32'h0, 32'h0, 32'h0000_0001, 1'b0, "R9");

        s = 32'h1234_5679;
        for (int i = 0; i < 80; i++) begin
            logic [31:0] va, vb, vr;
            s ^= s << 13; s ^= s >> 17; s ^= s << 5;
            va = s ^ 32'hA5A5_0000;
            vb = {s[15:0], s[31:16]};
            vr = s;
            case (s[3:2])
                2'd0: vr[30:23] = 8'h00;
                2'd1: vr[30:23] = 8'hFF;
                default: ;
            endcase
            if (s[9]) va[30:23] = 8'h00;
            if (s[10]) vb[30:23] = 8'hFF;
            step(int'(s[5:4]), va, vb, vr, s[7:6] != 2'd0, "R8 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule